// File: doc/BRIEF.md
# Sequenced ADC Serial Interface Controller

This block is the host side of the serial link to a multi-channel 12-bit converter. A start request opens one chip-select frame. In that frame the controller generates the serial clock, shifts a 16-bit control word out to the converter and captures the 16-bit frame that comes back. The serial clock is also the converter's conversion clock, so once a frame begins it runs without a break until all bits are done.

The returned frame is split into a 4-bit channel tag, which is the first four bits received, and a 12-bit sample. The sample is widened to the output width in one of two ways, chosen by a coding flag in the control word of the same frame: zero-extended for straight binary, or sign-extended for two's complement. The result appears with a one-cycle valid strobe. A busy flag covers the frame and the idle gap that follows it. Start requests are ignored while busy is high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, cs_n_o and sclk_o are 1, busy_o and done_o are 0, and chan_o and sample_o are 0.
- R2: If start_i is 1 at a clock edge while the block is idle, cs_n_o goes to 0 after that edge. The control word, captured at that edge, then appears on adc_din_o MSB first, one bit for each serial-clock period. adc_din_o changes only when sclk_o goes low, and never while sclk_o is high.
- R3: One serial-clock period is CLK_DIV system clocks: CLK_DIV/2 cycles low, then CLK_DIV/2 cycles high. A frame holds exactly 16 periods with no pause between them. sclk_o is 1 whenever cs_n_o is 1.
- R4: adc_dout_i is sampled at the system-clock edge at which sclk_o rises. The first 4 bits received, first bit as MSB, form chan_o.
- R5: done_o pulses for exactly one cycle, in the cycle in which cs_n_o returns to 1 after the 16th period. chan_o and sample_o carry the new result in that same cycle.
- R6: Bit CODE_POS (default 4) of the captured control word selects the coding. With 0, sample_o is the last 12 received bits, zero-extended. With 1, those bits are sign-extended from bit 11.
- R7: busy_o is 1 from the cycle after an accepted start until the frame and its gap are over. A start_i seen while busy_o is 1 is ignored: it does not change the frame, its control word or the number of results.
- R8: After a frame, cs_n_o stays 1 for CLK_DIV cycles, one full serial period, with busy_o still 1. Only then can a new start be accepted. A start held high through the gap begins the next frame at the first idle edge.
- R9: chan_o and sample_o hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one frame; sampled when idle |
| ctrl_word_i | input | 16 | Control word to send in the frame |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| done_o | output | 1 | One-cycle strobe: new result on chan_o/sample_o |
| chan_o | output | 4 | Channel tag from the returned frame |
| sample_o | output | 16 | Sample, zero- or sign-extended |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, high when idle |
| adc_din_o | output | 1 | Serial control data to the converter |
| adc_dout_i | input | 1 | Serial result data from the converter |

## Verification
The hardest thing to pin down from the ports is the exact capture instant inside each serial period. A converter model that holds each bit for a whole period cannot tell a capture at the rising edge from one a cycle early or late. The bench therefore drives the correct data bit only in the last low-half cycle before sclk_o rises, and drives its complement in every other cycle of the frame. A shifted sampling point then shows up as wrong tag or sample bits. A second hard-to-reach case is a start that arrives mid-frame or is held through the gap. The bench pokes start_i with a different control word partway through a frame, and holds start_i high across the gap, checking that the frame count and the first edge of the next frame are unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } seq_state_t;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic half_o,
   output logic end_o
);
   localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int HALF = CLK_DIV / 2;

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run_i) begin
         phase_q <= '0;
      end else if (phase_q == CW'(CLK_DIV - 1)) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign half_o = run_i && (phase_q == CW'(HALF - 1));
   assign end_o  = run_i && (phase_q == CW'(CLK_DIV - 1));
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] word_i,
   input  logic               adv_i,
   input  logic               cap_i,
   input  logic               sdi_i,
   output logic               sdo_o,
   output logic [FRAME_W-1:0] rx_o,
   output logic               last_o
);
   localparam int CNT_W = $clog2(FRAME_W);

   logic [FRAME_W-1:0] tx_q;
   logic [FRAME_W-1:0] rx_q;
   logic [CNT_W-1:0]   cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         tx_q  <= word_i;
         cnt_q <= '0;
      end else if (adv_i) begin
         tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (cap_i) begin
         rx_q <= {rx_q[FRAME_W-2:0], sdi_i};
      end
   end

   assign sdo_o  = tx_q[FRAME_W-1];
   assign rx_o   = rx_q;
   assign last_o = (cnt_q == CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
   parameter int SAMP_W = 12,
   parameter int OUT_W  = 16
) (
   input  logic              code_i,
   input  logic [SAMP_W-1:0] raw_i,
   output logic [OUT_W-1:0]  val_o
);
   generate
      if (OUT_W > SAMP_W) begin : g_ext
         localparam int PAD = OUT_W - SAMP_W;
         logic fill;
         assign fill  = code_i & raw_i[SAMP_W-1];
         assign val_o = {{PAD{fill}}, raw_i};
      end else begin : g_flat
         logic unused_code;
         assign unused_code = code_i;
         assign val_o = raw_i;
      end
   endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CLK_DIV  = 4,
   parameter int TAG_W    = 4,
   parameter int SAMP_W   = 12,
   parameter int OUT_W    = 16,
   parameter int CODE_POS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [TAG_W+SAMP_W-1:0]   ctrl_word_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [TAG_W-1:0]          chan_o,
   output logic [OUT_W-1:0]          sample_o,
   output logic                      cs_n_o,
   output logic                      sclk_o,
   output logic                      adc_din_o,
   input  logic                      adc_dout_i
);
   localparam int FRAME_W = TAG_W + SAMP_W;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (OUT_W < SAMP_W) begin : g_bad_out
         $error("OUT_W must not be narrower than SAMP_W");
      end
      if (CODE_POS < 0 || CODE_POS >= FRAME_W) begin : g_bad_code
         $error("CODE_POS must lie inside the control word");
      end
   endgenerate

   seq_state_t         state_q;
   logic               tick_half;
   logic               tick_end;
   logic               last_bit;
   logic               run;
   logic               launch;
   logic               capture;
   logic               advance;
   logic               code_q;
   logic [FRAME_W-1:0] rx_word;
   logic [OUT_W-1:0]   fmt_val;

   assign run     = (state_q != ST_IDLE);
   assign launch  = (state_q == ST_IDLE) && start_i;
   assign capture = (state_q == ST_SHIFT) && tick_half;
   assign advance = (state_q == ST_SHIFT) && tick_end && !last_bit;

   adc_seq_timer #(.CLK_DIV(CLK_DIV)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .half_o (tick_half),
      .end_o  (tick_end)
   );

   adc_seq_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (launch),
      .word_i (ctrl_word_i),
      .adv_i  (advance),
      .cap_i  (capture),
      .sdi_i  (adc_dout_i),
      .sdo_o  (adc_din_o),
      .rx_o   (rx_word),
      .last_o (last_bit)
   );

   adc_seq_fmt #(.SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_fmt (
      .code_i (code_q),
      .raw_i  (rx_word[SAMP_W-1:0]),
      .val_o  (fmt_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cs_n_o   <= 1'b1;
         sclk_o   <= 1'b1;
         done_o   <= 1'b0;
         code_q   <= 1'b0;
         chan_o   <= '0;
         sample_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_SHIFT;
                  cs_n_o  <= 1'b0;
                  sclk_o  <= 1'b0;
                  code_q  <= ctrl_word_i[CODE_POS];
               end
            end
            ST_SHIFT: begin
               if (tick_half) begin
                  sclk_o <= 1'b1;
               end
               if (tick_end) begin
                  if (last_bit) begin
                     state_q  <= ST_GAP;
                     cs_n_o   <= 1'b1;
                     done_o   <= 1'b1;
                     chan_o   <= rx_word[FRAME_W-1 -: TAG_W];
                     sample_o <= fmt_val;
                  end else begin
                     sclk_o <= 1'b0;
                  end
               end
            end
            ST_GAP: begin
               if (tick_end) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = run;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic cs_n_o,
   input logic sclk_o,
   input logic adc_din_o
);
   // R2: accepted start opens the frame
   a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !cs_n_o));

   // R2: data to the converter never moves while the serial clock is high
   a_r2_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> $stable(adc_din_o));

   // R3: clock parked high outside a frame
   a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   // R5: strobe lasts one cycle
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5: strobe coincides with chip select release
   a_r5_done_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $rose(cs_n_o));

   a_r5_cs_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> done_o);

   // R7: busy holds for the whole frame
   a_r7_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> busy_o);

   // R8: gap follows every frame with busy still set
   a_r8_gap_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |=> (cs_n_o && busy_o));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .cs_n_o    (cs_n_o),
   .sclk_o    (sclk_o),
   .adc_din_o (adc_din_o)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam int NBIT = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] ctrl = '0;
   logic        miso = 1'b0;
   logic        busy, done, cs_n, sclk, din;
   logic [3:0]  chan;
   logic [15:0] samp;

   logic [15:0] rsp_word = '0;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   adc_seq_ctrl u_adc_seq_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .ctrl_word_i (ctrl),
      .busy_o      (busy),
      .done_o      (done),
      .chan_o      (chan),
      .sample_o    (samp),
      .cs_n_o      (cs_n),
      .sclk_o      (sclk),
      .adc_din_o   (din),
      .adc_dout_i  (miso)
   );

   // reference model state
   int          m_state = 0;
   int          m_t = 0;
   int          m_g = 0;
   logic [15:0] m_ctrl = '0;
   logic [15:0] m_rsp = '0;
   logic        m_code = 1'b0;
   logic        e_done = 1'b0;
   logic [3:0]  e_chan = '0;
   logic [15:0] e_samp = '0;
   int          e_done_cnt = 0;
   int          d_done_cnt = 0;
   bit          cmp_on = 0;

   function automatic logic [15:0] widen(input logic [11:0] raw, input logic code);
      int v;
      v = raw;
      if (code && v >= 2048) v = v - 4096 + 65536;
      return 16'(v);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_t = 0; m_g = 0; e_done = 0;
         e_chan = '0; e_samp = '0;
      end else begin
         e_done = 0;
         case (m_state)
            0: if (start) begin
               m_state = 1; m_t = 0; m_ctrl = ctrl; m_rsp = rsp_word;
               m_code = ctrl[4];
            end
            1: begin
               m_t++;
               if (m_t == NBIT * DIV) begin
                  m_state = 2; m_g = 0; e_done = 1; e_done_cnt++;
                  e_chan = m_rsp[15:12];
                  e_samp = widen(m_rsp[11:0], m_code);
               end
            end
            default: begin
               m_g++;
               if (m_g == DIV) m_state = 0;
            end
         endcase
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every cycle, then drive the converter model
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         logic e_cs, e_sclk, e_busy;
         e_busy = (m_state != 0);
         e_cs   = (m_state != 1);
         e_sclk = (m_state != 1) ? 1'b1 : ((m_t % DIV) >= HALF);
         check(cs_n == e_cs, (m_state == 2) ? "R8 cs_n in gap" : "R2 cs_n", 32'(cs_n), 32'(e_cs));
         check(sclk == e_sclk, "R3 sclk", 32'(sclk), 32'(e_sclk));
         check(busy == e_busy, (m_state == 2) ? "R8 busy in gap" : "R7 busy", 32'(busy), 32'(e_busy));
         check(done == e_done, "R5 done", 32'(done), 32'(e_done));
         if (m_state == 1)
            check(din == m_ctrl[15 - m_t / DIV], "R2 din bit", 32'(din), 32'(m_ctrl[15 - m_t / DIV]));
         check(chan == e_chan, e_done ? "R4 chan" : "R9 chan hold", 32'(chan), 32'(e_chan));
         check(samp == e_samp, e_done ? "R6 sample" : "R9 sample hold", 32'(samp), 32'(e_samp));
         if (done) d_done_cnt++;
      end
      if (m_state == 1) begin
         logic b;
         b = m_rsp[15 - m_t / DIV];
         miso <= ((m_t % DIV) == HALF - 1) ? b : ~b;
      end else begin
         miso <= 1'b0;
      end
   end

   task automatic wait_idle();
      while (m_state != 0) @(negedge clk);
   endtask

   task automatic frame(input logic [15:0] c, input logic [15:0] r, input bit poke);
      @(negedge clk);
      start = 1'b1; ctrl = c; rsp_word = r;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (20) @(negedge clk);
         start = 1'b1; ctrl = ~c; rsp_word = ~r;
         @(negedge clk);
         start = 1'b0; rsp_word = r;
      end
      wait_idle();
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 32'd1);
      check(sclk == 1'b1, "R1 sclk", 32'(sclk), 32'd1);
      check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
      check(done == 1'b0, "R1 done", 32'(done), 32'd0);
      check(samp == 16'd0 && chan == 4'd0, "R1 result", {12'd0, chan, samp}, 32'd0);
      rst_n = 1'b1;
      cmp_on = 1;
      @(negedge clk);
      check(cs_n == 1'b1 && busy == 1'b0, "R1 after release", 32'({cs_n, busy}), 32'b10);

      frame(16'hA5C0, 16'h3ABC, 0);   // R6 unsigned, top sample bit set
      frame(16'h5A30, 16'h5ABC, 0);   // R6 signed negative
      frame(16'h1210, 16'h7123, 0);   // R6 signed positive
      frame(16'hFFEF, 16'hF000, 0);   // R4 tag all ones
      frame(16'h0010, 16'h0FFF, 0);   // R6 signed minus one
      frame(16'h8001, 16'h0FFF, 0);   // R6 unsigned full scale
      frame(16'hC3D2, 16'h9800, 1);   // R7 mid-frame start ignored
      repeat (7) @(negedge clk);      // R9 outputs idle and held

      // R8 start held through the gap
      @(negedge clk);
      start = 1'b1; ctrl = 16'h6B5F; rsp_word = 16'h2801;
      while (!e_done) @(negedge clk);
      ctrl = 16'h4C1A; rsp_word = 16'hE7FE;
      while (m_state != 1) @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (5) @(negedge clk);

      check(d_done_cnt == e_done_cnt, "R7 result count", 32'(d_done_cnt), 32'(e_done_cnt));
      check(e_done_cnt == 9, "R7 frame count", 32'(e_done_cnt), 32'd9);
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R7 watchdog: actual hung expected idle");
         summary();
         $finish;
      end
   end
endmodule